// File: doc/BRIEF.md
# Floating-Point to Fixed-Point Converter

This block turns a binary floating-point word (sign in the top bit, a biased exponent field under it, the fraction field in the low bits) into a two's-complement fixed-point word with a chosen number of fraction bits. Both formats are set when the block is built. The float side has a total width, an exponent width and a fraction width. The fixed side has a total width and a fraction-bit count. The same source therefore covers single-precision words feeding a 32-bit word with 20 fraction bits, double-precision words feeding a 64-bit word with 47 fraction bits, and narrower or odd-width formats such as 51 bits with 30 fraction bits.

The fraction-bit count (the radix point) is either a build constant or a runtime input sampled with each word. A build option chooses between the two. The conversion is a single registered stage. The block classifies the input and restores the hidden one of normal numbers. From the exponent and the radix point it works out a shift direction and amount. A bidirectional barrel shifter moves the significand into place, and the sign is applied after the shift. Values whose magnitude does not fit in the fixed word set an overflow flag and saturate.

Top module: `f2x_convert`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `fix_out` is all zeros and `ovf_out` is 0.
- R2: The result for the word on `flt_in` (and `radix_in`) before a rising clock edge appears on the outputs after that edge and holds until the next edge.
- R3: An input whose exponent field is all zeros (zero or subnormal, either sign) gives `fix_out` = 0 and `ovf_out` = 0.
- R4: An input whose exponent field is all ones (infinity or NaN) sets `ovf_out`. `fix_out` is 0x7F..F when the sign bit is 0 and 0x80..0 when the sign bit is 1.
- R5: A normal input of value v gives `fix_out` = v x 2^radix truncated toward zero, in two's complement. The magnitude is truncated first and then negated for a set sign bit. The exponent bias is 2^(EXP_W-1)-1, and the hidden one is restored above the fraction field.
- R6: For a normal input, let M be the truncated magnitude. If M >= 2^(FIX_W-1) for a positive input, or M > 2^(FIX_W-1) for a negative one, `ovf_out` is set and the output saturates as in R4. A negative input with M = 2^(FIX_W-1) is representable and gives 0x80..0 without overflow.
- R7: With RADIX_FROM_PORT = 1, the radix point used for each word is the unsigned value on `radix_in` sampled with that word, over its full range.
- R8: With RADIX_FROM_PORT = 0, the radix point is the parameter FRAC_BITS, and `radix_in` has no effect on the outputs.
- R9: The same design converts 32-bit words (8-bit exponent) into a 32-bit word with 20 fraction bits, and 64-bit words (11-bit exponent) into a 64-bit word with 47 fraction bits, following R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_in | input | FLT_W | Floating-point word: sign, exponent field, fraction field |
| radix_in | input | RADIX_W | Fraction-bit count when RADIX_FROM_PORT = 1; ignored otherwise |
| fix_out | output | FIX_W | Two's-complement fixed-point result |
| ovf_out | output | 1 | Set when the value cannot be represented (including infinity and NaN) |

## Verification
Every internal decision reaches the ports within one clock, since only the output register lies between input and output. A wrong shift direction or amount shows up as a result off by a power of two. A wrong class decode turns zeros or infinities into ordinary numbers. A slip in the overflow boundary shows up at the largest exponents, especially at the one negative value that fits exactly. Sweeping every word of a 16-bit float format against an arithmetic model, under every radix value, puts each of these boundaries in front of the output register.

// File: rtl/f2x_pkg.sv
package f2x_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_NORMAL  = 2'd1,
        CLS_SPECIAL = 2'd2
    } flt_class_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/f2x_classify.sv
module f2x_classify
    import f2x_pkg::*;
#(
    parameter int FLT_W = 32,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [FLT_W-1:0] flt,
    output logic             sign,
    output flt_class_e       cls,
    output logic [EXP_W-1:0] exp_field,
    output logic [MAN_W:0]   sig
);

    always_comb begin
        sign      = flt[FLT_W-1];
        exp_field = flt[FLT_W-2 -: EXP_W];
        // hidden one restored above the fraction field
        sig       = {1'b1, flt[MAN_W-1:0]};
        if (exp_field == '0) begin
            cls = CLS_ZERO;          // zero and subnormals are flushed
        end else if (&exp_field) begin
            cls = CLS_SPECIAL;       // infinity or NaN
        end else begin
            cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/f2x_shift_calc.sv
module f2x_shift_calc #(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter int FIX_W   = 32,
    parameter int RADIX_W = 6,
    parameter int W       = 32,
    parameter int SH_W    = 5,
    parameter int CW      = 12
) (
    input  logic [EXP_W-1:0]   exp_field,
    input  logic [RADIX_W-1:0] radix,
    output logic               shl,
    output logic [SH_W-1:0]    amt,
    output logic               kill,
    output logic               big
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic signed [CW-1:0] lead_pos;   // bit index of the leading one in the fixed word
    logic signed [CW-1:0] shift_s;
    logic        [CW-1:0] shift_mag;

    always_comb begin
        lead_pos  = $signed({{(CW-EXP_W){1'b0}}, exp_field})
                  - $signed(CW'(BIAS))
                  + $signed({{(CW-RADIX_W){1'b0}}, radix});
        shift_s   = lead_pos - $signed(CW'(MAN_W));
        big       = lead_pos > $signed(CW'(FIX_W - 1));
        shl       = !shift_s[CW-1];
        shift_mag = shl ? shift_s : -shift_s;
        kill      = shift_mag >= CW'(W);
        amt       = shift_mag[SH_W-1:0];
    end

endmodule

// File: rtl/f2x_shifter.sv
module f2x_shifter #(
    parameter int IN_W = 24,
    parameter int W    = 32,
    parameter int SH_W = 5
) (
    input  logic [IN_W-1:0] sig,
    input  logic            shl,
    input  logic [SH_W-1:0] amt,
    input  logic            kill,
    output logic [W-1:0]    res
);

    logic [W-1:0] stage [SH_W+1];

    assign stage[0] = W'(sig);

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (STEP >= W) begin : g_flush
            assign stage[k+1] = amt[k] ? '0 : stage[k];
        end else begin : g_move
            assign stage[k+1] = !amt[k] ? stage[k]
                              : (shl ? (stage[k] << STEP) : (stage[k] >> STEP));
        end
    end

    assign res = kill ? '0 : stage[SH_W];

endmodule

// File: rtl/f2x_convert.sv
module f2x_convert
    import f2x_pkg::*;
#(
    parameter int FLT_W           = 32,
    parameter int EXP_W           = 8,
    parameter int MAN_W           = 23,
    parameter int FIX_W           = 32,
    parameter int FRAC_BITS       = 20,
    parameter int RADIX_W         = 6,
    parameter bit RADIX_FROM_PORT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLT_W-1:0]   flt_in,
    input  logic [RADIX_W-1:0] radix_in,
    output logic [FIX_W-1:0]   fix_out,
    output logic               ovf_out
);

    localparam int SIG_W = MAN_W + 1;
    localparam int W     = imax(FIX_W, SIG_W);
    localparam int SH_W  = imax($clog2(W), 1);
    localparam int CW    = imax(imax(EXP_W, RADIX_W),
                                imax($clog2(SIG_W + 1), $clog2(FIX_W + 1))) + 3;
    localparam logic [FIX_W-1:0] FIX_MAX = {1'b0, {(FIX_W-1){1'b1}}};
    localparam logic [FIX_W-1:0] FIX_MIN = {1'b1, {(FIX_W-1){1'b0}}};

    typedef struct packed {
        logic [FIX_W-1:0] fix;
        logic             ovf;
    } out_t;

    out_t out_d, out_q;

    logic               sign;
    flt_class_e         cls;
    logic [EXP_W-1:0]   exp_field;
    logic [SIG_W-1:0]   sig;
    logic [RADIX_W-1:0] radix_eff;
    logic               shl, kill, big;
    logic [SH_W-1:0]    amt;
    logic [W-1:0]       shift_res;
    logic               hi_set;
    logic [FIX_W-1:0]   mag;
    logic               mag_ovf;

    // radix point source chosen at build time (R7, R8)
    if (RADIX_FROM_PORT) begin : g_radix_port
        assign radix_eff = radix_in;
    end else begin : g_radix_const
        assign radix_eff = RADIX_W'(FRAC_BITS);
    end

    f2x_classify #(
        .FLT_W (FLT_W),
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_classify (
        .flt       (flt_in),
        .sign      (sign),
        .cls       (cls),
        .exp_field (exp_field),
        .sig       (sig)
    );

    f2x_shift_calc #(
        .EXP_W   (EXP_W),
        .MAN_W   (MAN_W),
        .FIX_W   (FIX_W),
        .RADIX_W (RADIX_W),
        .W       (W),
        .SH_W    (SH_W),
        .CW      (CW)
    ) u_shift_calc (
        .exp_field (exp_field),
        .radix     (radix_eff),
        .shl       (shl),
        .amt       (amt),
        .kill      (kill),
        .big       (big)
    );

    f2x_shifter #(
        .IN_W (SIG_W),
        .W    (W),
        .SH_W (SH_W)
    ) u_shifter (
        .sig   (sig),
        .shl   (shl),
        .amt   (amt),
        .kill  (kill),
        .res   (shift_res)
    );

    if (W > FIX_W) begin : g_hi_bits
        assign hi_set = |shift_res[W-1:FIX_W];
    end else begin : g_no_hi_bits
        assign hi_set = 1'b0;
    end

    assign mag = shift_res[FIX_W-1:0];

    always_comb begin
        // the most negative code is the one magnitude with its top bit set that fits (R6)
        mag_ovf = big | hi_set | (mag[FIX_W-1] & ~(sign & ~|mag[FIX_W-2:0]));
        out_d   = '0;
        unique case (cls)
            CLS_ZERO: begin
                out_d = '0;
            end
            CLS_SPECIAL: begin
                out_d.ovf = 1'b1;
                out_d.fix = sign ? FIX_MIN : FIX_MAX;
            end
            CLS_NORMAL: begin
                if (mag_ovf) begin
                    out_d.ovf = 1'b1;
                    out_d.fix = sign ? FIX_MIN : FIX_MAX;
                end else begin
                    out_d.fix = sign ? -mag : mag;
                end
            end
            default: out_d = '0;
        endcase
    end

    // single output register; cleared by reset (R1), one cycle of latency (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign fix_out = out_q.fix;
    assign ovf_out = out_q.ovf;

    assert_zero_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_in[FLT_W-2 -: EXP_W] == '0) |=> (fix_out == '0 && !ovf_out));

    assert_special_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&flt_in[FLT_W-2 -: EXP_W]) |=>
            (ovf_out && fix_out == ($past(flt_in[FLT_W-1]) ? FIX_MIN : FIX_MAX)));

    assert_ovf_saturated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_out |-> (fix_out == FIX_MAX || fix_out == FIX_MIN));

    assert_pos_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_in[FLT_W-1] |=> !fix_out[FIX_W-1]);

    assert_neg_nonpos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_in[FLT_W-1] |=> (fix_out == '0 || fix_out[FIX_W-1]));

endmodule

// File: tb/f2x_convert_tb.sv
`timescale 1ns/1ps
module f2x_convert_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [15:0] flt16 = '0;
    logic [4:0]  rdx   = '0;
    logic [15:0] out16, outf;
    logic        ovf16, ovff;
    logic [31:0] flt32 = '0;
    logic [31:0] out32;
    logic        ovf32;
    logic [63:0] flt64 = '0;
    logic [63:0] out64;
    logic        ovf64;
    logic [5:0]  rdx_unused = '0;

    // small format, radix from the port
    f2x_convert #(.FLT_W(16), .EXP_W(5), .MAN_W(10), .FIX_W(16), .FRAC_BITS(0),
                  .RADIX_W(5), .RADIX_FROM_PORT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .flt_in(flt16), .radix_in(rdx),
        .fix_out(out16), .ovf_out(ovf16));

    // small format, constant radix 4; radix_in driven but must not matter
    f2x_convert #(.FLT_W(16), .EXP_W(5), .MAN_W(10), .FIX_W(16), .FRAC_BITS(4),
                  .RADIX_W(5), .RADIX_FROM_PORT(1'b0)) u_dut_const (
        .clk(clk), .rst_n(rst_n), .flt_in(flt16), .radix_in(rdx),
        .fix_out(outf), .ovf_out(ovff));

    f2x_convert #(.FLT_W(32), .EXP_W(8), .MAN_W(23), .FIX_W(32), .FRAC_BITS(20),
                  .RADIX_W(6), .RADIX_FROM_PORT(1'b0)) u_dut_sgl (
        .clk(clk), .rst_n(rst_n), .flt_in(flt32), .radix_in(rdx_unused),
        .fix_out(out32), .ovf_out(ovf32));

    f2x_convert #(.FLT_W(64), .EXP_W(11), .MAN_W(52), .FIX_W(64), .FRAC_BITS(47),
                  .RADIX_W(6), .RADIX_FROM_PORT(1'b0)) u_dut_dbl (
        .clk(clk), .rst_n(rst_n), .flt_in(flt64), .radix_in(rdx_unused),
        .fix_out(out64), .ovf_out(ovf64));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv,
                         input logic act_o, input logic exp_o);
        checks++;
        if (act !== expv || act_o !== exp_o) begin
            errors++;
            $display("FAIL %s: got %h ovf %b, expected %h ovf %b", tag, act, act_o, expv, exp_o);
        end
    endtask

    // arithmetic reference: value * 2^r, magnitude truncated, then signed
    task automatic model(input logic [63:0] bits, input int fw, input int ew, input int mw,
                         input int xw, input int r, output logic [63:0] ev, output logic eo);
        logic        s;
        int          e, bias;
        logic [63:0] m, mask, maxp, minn, u;
        real         mag, lim;
        s    = bits[fw-1];
        e    = int'((bits >> mw) & ((64'd1 << ew) - 1));
        m    = bits & ((64'd1 << mw) - 1);
        bias = (1 << (ew - 1)) - 1;
        mask = (xw == 64) ? '1 : ((64'd1 << xw) - 1);
        maxp = (64'd1 << (xw - 1)) - 1;
        minn = 64'd1 << (xw - 1);
        eo   = 1'b0;
        if (e == 0) begin
            ev = '0;
        end else if (e == (1 << ew) - 1) begin
            eo = 1'b1;
            ev = s ? minn : maxp;
        end else begin
            mag = $floor((2.0 ** mw + real'(m)) * 2.0 ** (e - bias - mw + r));
            lim = 2.0 ** (xw - 1);
            if ((!s && mag >= lim) || (s && mag > lim)) begin
                eo = 1'b1;
                ev = s ? minn : maxp;
            end else if (s && mag == lim) begin
                ev = minn;
            end else begin
                u  = 64'(longint'(mag));
                ev = s ? ((-u) & mask) : u;
            end
        end
    endtask

    // one vector per cycle: drive at the falling edge, sample 1 ns after the rising edge
    task automatic run16(input logic [15:0] f, input int r, input string main_tag);
        logic [63:0] ev;
        logic        eo;
        int          e;
        string       tag;
        @(negedge clk);
        flt16 = f;
        rdx   = 5'(r);
        @(posedge clk);
        #1;
        model({48'b0, f}, 16, 5, 10, 16, r, ev, eo);
        e   = int'(f[14:10]);
        tag = (e == 0) ? "R3" : (e == 31) ? "R4" : eo ? "R6" : main_tag;
        check(tag, {48'b0, out16}, ev, ovf16, eo);
        model({48'b0, f}, 16, 5, 10, 16, 4, ev, eo);
        check("R8", {48'b0, outf}, ev, ovff, eo);
    endtask

    task automatic run32(input logic [31:0] f);
        logic [63:0] ev;
        logic        eo;
        @(negedge clk);
        flt32 = f;
        @(posedge clk);
        #1;
        model({32'b0, f}, 32, 8, 23, 32, 20, ev, eo);
        check("R9 single", {32'b0, out32}, ev, ovf32, eo);
    endtask

    task automatic run64(input logic [63:0] f, input logic [63:0] ev, input logic eo);
        logic [63:0] mv;
        logic        mo;
        @(negedge clk);
        flt64 = f;
        @(posedge clk);
        #1;
        model(f, 64, 11, 52, 64, 47, mv, mo);
        check("R9 double", out64, ev, ovf64, eo);
        check("R9 double model", out64, mv, ovf64, mo);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        flt16 = 16'h3C00;
        flt64 = 64'h3FF0_0000_0000_0000;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {48'b0, out16}, '0, ovf16, 1'b0);
        check("R1 reset", out64, '0, ovf64, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", {48'b0, out16}, '0, ovf16, 1'b0);

        // latency: 2.0 at radix 6 -> 128, then 1.0 -> 64 one edge later (R2)
        run16(16'h4000, 6, "R5");
        @(negedge clk);
        flt16 = 16'h3C00;
        rdx   = 5'd6;
        #1;
        check("R2 holds", {48'b0, out16}, 64'd128, ovf16, 1'b0);
        @(posedge clk);
        #1;
        check("R2 updates", {48'b0, out16}, 64'd64, ovf16, 1'b0);

        // every 16-bit word at one radix (R5, R3, R4, R6)
        for (int i = 0; i < 65536; i++) begin
            run16(16'(i), 6, "R5");
        end

        // every radix value over a stride of words (R7)
        for (int r = 0; r < 32; r++) begin
            for (int k = 0; k < 2048; k++) begin
                run16(16'((k * 32 + r * 7) & 16'hFFFF), r, "R7");
            end
        end

        // 32-bit words into 32-bit fixed with 20 fraction bits (R9)
        run32(32'h3F80_0000);
        run32(32'hC020_0000);
        run32(32'h4500_0000);
        run32(32'hC500_0000);
        run32(32'h33D6_BF95);
        run32(32'h7F80_0000);
        run32(32'hFFC0_0000);
        run32(32'h0000_0001);
        run32(32'h44FF_FFFF);

        // 64-bit words into 64-bit fixed with 47 fraction bits (R9)
        run64($realtobits(1.0),      64'h0000_8000_0000_0000, 1'b0);
        run64($realtobits(-1.5),     64'hFFFF_4000_0000_0000, 1'b0);
        run64($realtobits(65536.0),  64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
        run64($realtobits(-65536.0), 64'h8000_0000_0000_0000, 1'b0);
        run64($realtobits(0.0),      64'h0,                   1'b0);
        run64(64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule